// File: doc/BRIEF.md
# Serial Control and Readout Slave

This block is a two-wire serial bus slave that sits between a host microcontroller and a small data-acquisition core. The host sends one byte to configure an 8-bit control register, and it reads back up to sixteen captured bytes from a transfer buffer. Each read has no pointer phase. A start condition rewinds the internal byte counter to the first buffer entry, and every acknowledge from the master advances it by one.

The bus lines are modelled as open-drain. The block takes the line levels on `scl_i` and `sda_i`. It pulls SDA low through `sda_oe`, and `sda_o` is a constant zero. Both lines pass through a synchronizer with a parameterized depth. Start, stop and clock-edge events are then decoded from the synchronized levels. The slave address is the pair 0x20/0x21 or 0x22/0x23 (write/read, 8-bit form), chosen by `addr_sel`. From the moment the address matches until the next stop, `busy` is high. This tells the acquisition side not to overwrite the buffer in the middle of a transfer.

The controller is a state machine with eight states:
- `S_IDLE`: bus free or not addressed.
- `S_ADDR`: shifting in the address byte.
- `S_AACK`: acknowledging the address.
- `S_WDATA`: shifting in the control byte.
- `S_WACK`: acknowledging the control byte.
- `S_RDATA`: driving a byte out.
- `S_RACK`: sampling the master's acknowledge.
- `S_SKIP`: ignoring the bus until the next start or stop.

The transitions are:
- Stop, from any state: go to `S_IDLE`.
- Start, from any state: go to `S_ADDR`.
- `S_ADDR` → `S_AACK`, after eight bits with a matching address.
- `S_ADDR` → `S_SKIP`, after eight bits with no match.
- `S_AACK` → `S_RDATA` or `S_WDATA`, on the falling SCL edge, according to the direction bit.
- `S_WDATA` → `S_WACK`, after eight bits.
- `S_WACK` → `S_SKIP`, on the falling edge.
- `S_RDATA` → `S_RACK`, after the eighth falling edge.
- `S_RACK` → `S_RDATA` on a master acknowledge, or → `S_SKIP` on a not-acknowledge.

Top module: `i2c_ctl_slave`

## Requirements
- R1: The 7-bit slave address is `{6'b001000, addr_sel}`, so the 8-bit forms are 0x20 (write) and 0x21 (read) when `addr_sel`=0, and 0x22 and 0x23 when `addr_sel`=1. Any other address receives no acknowledge, leaves `busy` low and leaves `ctrl_reg` unchanged.
- R2: In a write, the slave acknowledges the address and the single data byte. `ctrl_reg` takes the received byte (MSB first) and changes at no other time.
- R3: After reset, `ctrl_reg` is 0x00, `busy` is 0 and `sda_oe` is 0.
- R4: Every start condition sets the byte counter to buffer entry 0. A read then shifts out entry 0 MSB first, beginning on the falling SCL edge that ends the address acknowledge.
- R5: A master acknowledge (SDA low on the ninth clock) increments the counter shown on `buf_idx`. The next byte is then taken from `buf_data` at that index.
- R6: A master not-acknowledge ends transmission. The slave drives SDA no more until the next start condition.
- R7: The counter saturates at 16. Bytes requested after the sixteenth byte of a read are 0xFF.
- R8: `busy` rises when a matching address has been received and falls on the next stop condition.
- R9: The slave drives SDA low only while `busy` is high. It changes its SDA drive only while the synchronized SCL is low, or right after a start or stop.
- R10: A second data byte in a write transaction gets no acknowledge and does not alter `ctrl_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| addr_sel | input | 1 | Selects address pair 0x20/0x21 (0) or 0x22/0x23 (1) |
| sda_o | output | 1 | SDA output value, constant 0 (open-drain) |
| sda_oe | output | 1 | High pulls SDA low |
| ctrl_reg | output | 8 | Control register written by the host |
| buf_idx | output | 4 | Transfer-buffer index being read |
| buf_data | input | 8 | Buffer byte at `buf_idx` |
| busy | output | 1 | High while addressed, until stop |

## Verification
The embedded assertions check the following on every clock:
- SDA is never driven while `busy` is low.
- The SDA drive changes only in the SCL-low phase or right after a start or stop.
- The byte counter returns to zero after each start and never exceeds sixteen.
- `busy` drops after every stop.
- `ctrl_reg` moves only out of the write-data state.

Some behaviour can only be shown by the bench's bus-level scenarios:
- Rejection of the wrong address for each `addr_sel` value.
- The exact bytes read in order, including the 0xFF tail after sixteen bytes.
- A restart of the read at entry 0.
- The missing acknowledge on a second write byte.
- Silence on SDA after a not-acknowledge.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_WDATA,
        S_WACK,
        S_RDATA,
        S_RACK,
        S_SKIP
    } i2cs_state_t;

    localparam int BYTE_BITS = 8;
    localparam logic [7:0] PAST_END_BYTE = 8'hFF;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '1;
                else        pipe[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[g] <= '1;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ctl_slave.sv
module i2c_ctl_slave
    import i2cs_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         BUF_BYTES   = 16,
    parameter logic [5:0] ADDR_HI     = 6'b001000,
    localparam int        IDX_W       = $clog2(BUF_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic             addr_sel,
    output logic             sda_o,
    output logic             sda_oe,
    output logic [7:0]       ctrl_reg,
    output logic [IDX_W-1:0] buf_idx,
    input  logic [7:0]       buf_data,
    output logic             busy
);
    localparam int CNT_W = $clog2(BUF_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BUF_BYTES);
    localparam logic [3:0] BIT_FULL = 4'(BYTE_BITS);
    localparam logic [3:0] BIT_LAST = 4'(BYTE_BITS - 1);

    logic [1:0] lines_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_c, stop_c;

    i2cs_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({scl_i, sda_i}),
        .q     (lines_s)
    );
    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    i2cs_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    i2cs_state_t      state, nxt;
    logic [7:0]       shreg;
    logic [3:0]       bitcnt;
    logic [CNT_W-1:0] rd_cnt;
    logic             m_ack;
    logic             addr_hit;
    logic [7:0]       fetch;

    assign addr_hit = (shreg[7:1] == {ADDR_HI, addr_sel});
    assign fetch    = (rd_cnt >= CNT_MAX) ? PAST_END_BYTE : buf_data;
    assign buf_idx  = rd_cnt[IDX_W-1:0];

    always_comb begin
        nxt = state;
        if (stop_c) begin
            nxt = S_IDLE;
        end else if (start_c) begin
            nxt = S_ADDR;
        end else begin
            unique case (state)
                S_IDLE:  nxt = S_IDLE;
                S_ADDR:  if (scl_fall && bitcnt == BIT_FULL) nxt = addr_hit ? S_AACK : S_SKIP;
                S_AACK:  if (scl_fall) nxt = shreg[0] ? S_RDATA : S_WDATA;
                S_WDATA: if (scl_fall && bitcnt == BIT_FULL) nxt = S_WACK;
                S_WACK:  if (scl_fall) nxt = S_SKIP;
                S_RDATA: if (scl_fall && bitcnt == BIT_LAST) nxt = S_RACK;
                S_RACK:  if (scl_fall) nxt = m_ack ? S_RDATA : S_SKIP;
                S_SKIP:  nxt = S_SKIP;
                default: nxt = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            bitcnt   <= '0;
            rd_cnt   <= '0;
            m_ack    <= 1'b0;
            ctrl_reg <= '0;
            busy     <= 1'b0;
        end else if (stop_c) begin
            busy   <= 1'b0;
            bitcnt <= '0;
        end else if (start_c) begin
            bitcnt <= '0;
            rd_cnt <= '0;
        end else begin
            unique case (state)
                S_ADDR, S_WDATA: begin
                    if (scl_rise) begin
                        shreg  <= {shreg[6:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (scl_fall && bitcnt == BIT_FULL) begin
                        if (state == S_ADDR && addr_hit) busy <= 1'b1;
                        if (state == S_WDATA) ctrl_reg <= shreg;
                    end
                end
                S_AACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (shreg[0]) shreg <= fetch;
                    end
                end
                S_RDATA: begin
                    if (scl_fall) begin
                        shreg  <= {shreg[6:0], 1'b1};
                        bitcnt <= bitcnt + 4'd1;
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_s;
                        if (!sda_s && rd_cnt < CNT_MAX) rd_cnt <= rd_cnt + 1'b1;
                    end
                    if (scl_fall && m_ack) begin
                        shreg  <= fetch;
                        bitcnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        sda_o  = 1'b0;
        sda_oe = 1'b0;
        unique case (state)
            S_AACK, S_WACK: sda_oe = 1'b1;
            S_RDATA:        sda_oe = ~shreg[7];
            default:        sda_oe = 1'b0;
        endcase
    end

    a_r9_drive_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> busy);

    a_r9_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> (!scl_s || $past(start_c) || $past(stop_c)));

    a_r4_start_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        start_c && !stop_c |=> rd_cnt == '0);

    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rd_cnt <= CNT_MAX);

    a_r8_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        stop_c |=> !busy);

    a_r2_ctrl_from_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_reg) |-> $past(state) == S_WDATA);
endmodule

// File: tb/i2c_ctl_slave_test.sv
module i2c_ctl_slave_test;
    localparam int Q = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       addr_sel = 1'b0;
    logic       sda_o, sda_oe, busy;
    logic [7:0] ctrl_reg;
    logic [3:0] buf_idx;
    logic [7:0] buf_data;
    logic       sda_line;
    logic [7:0] mem [16];

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;
    assign buf_data = mem[buf_idx];

    i2c_ctl_slave uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (m_scl),
        .sda_i    (sda_line),
        .addr_sel (addr_sel),
        .sda_o    (sda_o),
        .sda_oe   (sda_oe),
        .ctrl_reg (ctrl_reg),
        .buf_idx  (buf_idx),
        .buf_data (buf_data),
        .busy     (busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wcyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wcyc(Q);
        m_sda = 1'b0; wcyc(Q);
        m_scl = 1'b0; wcyc(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wcyc(Q);
        m_scl = 1'b1; wcyc(Q);
        m_sda = 1'b1; wcyc(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; wcyc(Q);
            m_scl = 1'b1; wcyc(Q);
            m_scl = 1'b0; wcyc(Q/2);
        end
        m_sda = 1'b1; wcyc(Q);
        m_scl = 1'b1; wcyc(Q/2);
        ack = ~sda_line;
        wcyc(Q/2);
        m_scl = 1'b0; wcyc(Q);
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wcyc(Q);
            m_scl = 1'b1; wcyc(Q/2);
            b[i] = sda_line;
            wcyc(Q/2);
            m_scl = 1'b0;
        end
        wcyc(Q/2);
        m_sda = ~give_ack; wcyc(Q);
        m_scl = 1'b1; wcyc(Q);
        m_scl = 1'b0; wcyc(Q/2);
        m_sda = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic       ack;
        logic [7:0] rb;
        int         exp_ctrl;
        for (int i = 0; i < 16; i++) mem[i] = 8'(8'h3C ^ (i * 37));
        exp_ctrl = 0;
        wcyc(5);
        rst_n = 1'b1;
        wcyc(3);
        // R3 reset state
        chk("R3 ctrl after reset", ctrl_reg, 0);
        chk("R3 busy after reset", busy, 0);
        chk("R3 sda_oe after reset", sda_oe, 0);

        // R1/R2 write with addr_sel=0
        addr_sel = 1'b0;
        bus_start();
        send_byte(8'h20, ack);
        chk("R1 addr 0x20 ack", ack, 1);
        chk("R8 busy after match", busy, 1);
        send_byte(8'h5A, ack);
        chk("R2 data ack", ack, 1);
        bus_stop();
        exp_ctrl = 8'h5A;
        chk("R2 ctrl written", ctrl_reg, exp_ctrl);
        chk("R8 busy after stop", busy, 0);

        // R1 wrong address for addr_sel=0
        bus_start();
        send_byte(8'h22, ack);
        chk("R1 foreign addr no ack", ack, 0);
        chk("R1 foreign addr busy", busy, 0);
        send_byte(8'h11, ack);
        bus_stop();
        chk("R1 ctrl unchanged", ctrl_reg, exp_ctrl);

        // R10 two-byte write at addr_sel=1
        addr_sel = 1'b1;
        bus_start();
        send_byte(8'h20, ack);
        chk("R1 addr 0x20 rejected when sel=1", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'h22, ack);
        chk("R1 addr 0x22 ack when sel=1", ack, 1);
        send_byte(8'hA7, ack);
        chk("R2 first data ack", ack, 1);
        send_byte(8'h33, ack);
        chk("R10 second byte no ack", ack, 0);
        bus_stop();
        exp_ctrl = 8'hA7;
        chk("R10 ctrl keeps first byte", ctrl_reg, exp_ctrl);

        // R4/R5/R6 read three bytes
        bus_start();
        send_byte(8'h23, ack);
        chk("R1 read addr ack", ack, 1);
        for (int k = 0; k < 3; k++) begin
            recv_byte(k != 2, rb);
            chk(k == 0 ? "R4 first byte" : "R5 next byte", rb, mem[k]);
        end
        chk("R5 index after two acks", buf_idx, 2);
        recv_byte(1'b0, rb);
        chk("R6 line idle after nack", rb, 8'hFF);
        bus_stop();

        // R4 restart at entry 0
        bus_start();
        send_byte(8'h23, ack);
        recv_byte(1'b1, rb);
        chk("R4 restart byte0", rb, mem[0]);
        recv_byte(1'b0, rb);
        chk("R5 restart byte1", rb, mem[1]);
        bus_stop();

        // R7 read past the end
        bus_start();
        send_byte(8'h23, ack);
        for (int k = 0; k < 18; k++) begin
            recv_byte(k != 17, rb);
            if (k < 16) chk("R5 sequential byte", rb, mem[k]);
            else        chk("R7 past end byte", rb, 8'hFF);
        end
        bus_stop();
        chk("R8 busy low at end", busy, 0);
        chk("R2 ctrl unaffected by reads", ctrl_reg, exp_ctrl);

        finish_run();
    end
endmodule